// File: doc/BRIEF.md
# Sound Unit Register Port with Combined Status

This block sits between the CPU bus and a five-channel sound unit (two square-wave voices, one triangle voice, one noise voice and one sample-playback voice). It decodes byte accesses to a 24-byte window starting at a base address (default 0x4000). Each write to a channel register becomes a one-cycle write enable on a one-hot vector, indexed by the register's offset in the window, together with the written byte. The channels themselves sit outside this block and consume these strobes.

The block owns the combined status register at offset 0x15. Writing it sets the five channel enable bits. Reading it gathers the channels' "length still running" indications, the sample voice's activity and interrupt, and the frame interrupt flag, which this block holds. A strobed read of the status clears the frame interrupt flag. The same value can be observed without that side effect by presenting the address without the read strobe. A write to offset 0x17 is forwarded to the frame sequencer and also sets or releases an interrupt inhibit held here.

The block models a floating data bus. Any write leaves its byte in a latch, and a strobed status read leaves the returned status there. Every address other than the status returns that latch. Read data is combinational from the address. All side effects take place at the clock edge that samples a strobe.

Top module: `snd_status_port`

## Requirements
- R1: After reset the write-enable vector is zero, all five channel enables are 0, the frame interrupt flag and its inhibit are 0, and the bus latch holds 0x00.
- R2: A write strobe to a mapped offset o raises bit o of `regWr` in the cycle after the strobe, with `regWrData` equal to the written byte. The mapped offsets are 0x00–0x08, 0x0A–0x0C, 0x0E–0x13 and 0x17.
- R3: `regWr` has at most one bit set, and it is nonzero only in the cycle directly after a write strobe, so each write yields a single one-cycle pulse.
- R4: Writes to offsets 0x09, 0x0D, 0x14, 0x15 and 0x16, and to any address outside the window, raise no bit of `regWr`.
- R5: A write to offset 0x15 loads `chanEnable` from data bits 0–4 (bit 0 first square, bit 1 second square, bit 2 triangle, bit 3 noise, bit 4 sample), visible from the next cycle; bits 5–7 are ignored.
- R6: With the address at offset 0x15, `rdData` holds bits 0–3 = `lenActive[3:0]`, bit 4 = `smpActive`, bit 5 = 0, bit 6 = the frame interrupt flag and bit 7 = `smpIrq`.
- R7: The frame interrupt flag is set by a `frameIrqReq` pulse while not inhibited, and a strobed status read clears it. A request in the same cycle as the read wins, and the flag stays set.
- R8: Presenting offset 0x15 without `rdStrobe` returns the status word and leaves the flag unchanged.
- R9: Every write, to any address, loads the bus latch with its byte. A strobed status read loads the latch with the status returned. A read of any other address returns the latch.
- R10: A write to offset 0x17 sets the inhibit from data bit 6. A write with bit 6 set clears the flag at once, and while the inhibit is set, requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | ADDR_W | CPU address |
| cpuWrData | input | 8 | CPU write data |
| wrStrobe | input | 1 | One-cycle write request |
| rdStrobe | input | 1 | One-cycle read request (applies read side effects) |
| lenActive | input | 4 | Length-running flags of square 1, square 2, triangle, noise |
| smpActive | input | 1 | Sample voice still has bytes to play |
| smpIrq | input | 1 | Sample voice interrupt |
| frameIrqReq | input | 1 | Frame sequencer interrupt request pulse |
| regWr | output | 24 | One-hot channel register write enable, indexed by offset |
| regWrData | output | 8 | Byte for the register being written |
| chanEnable | output | 5 | Channel enable bits |
| rdData | output | 8 | Read data for the current address |

## Verification
The bench walks every offset of the window, including the holes and the status slot. A decoder that left a hole mapped would fire a stray strobe, and one off by one would fire the neighbour. It separates a peek from a strobed read: a design that cleared on a plain address match would lose the flag before any read. It collides a request with a clearing read, where the wrong priority drops an interrupt. It reads a non-status address after a status read and after writes outside the window, which shows whether the latch captured the status and every write.

// File: rtl/snd_port_pkg.sv
package snd_port_pkg;
  localparam int DATA_W      = 8;
  localparam int SLOT_N      = 24;
  localparam int OFFS_W      = $clog2(SLOT_N);
  localparam int CHAN_N      = 5;
  localparam int LEN_N       = 4;
  localparam int STATUS_OFFS = 'h15;
  localparam int FRAME_OFFS  = 'h17;
  localparam int INHIBIT_BIT = 6;

  typedef struct packed {
    logic busWrite;
    logic statusWrite;
    logic statusRead;
    logic frameWrite;
    logic statusSel;
  } portStrobes_t;

  function automatic logic isChanSlot(input int offs);
    return !(offs == 'h09 || offs == 'h0D || offs == 'h14 ||
             offs == STATUS_OFFS || offs == 'h16);
  endfunction
endpackage

// File: rtl/snd_port_ctrl.sv
module snd_port_ctrl
  import snd_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output logic [SLOT_N-1:0] slotHit,
  output portStrobes_t      strobes
);
  logic [ADDR_W-1:0] offsFull;
  logic              inWindow;
  logic [OFFS_W-1:0] offs;

  always_comb begin
    offsFull = cpuAddr - BASE_ADDR;
    inWindow = (cpuAddr >= BASE_ADDR) && (offsFull < ADDR_W'(SLOT_N));
    offs     = offsFull[OFFS_W-1:0];
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    if (isChanSlot(s)) begin : g_map
      assign slotHit[s] = wrStrobe && inWindow && (offs == OFFS_W'(s));
    end else begin : g_hole
      assign slotHit[s] = 1'b0;
    end
  end

  always_comb begin
    strobes.statusSel   = inWindow && (offs == OFFS_W'(STATUS_OFFS));
    strobes.busWrite    = wrStrobe;
    strobes.statusWrite = wrStrobe && strobes.statusSel;
    strobes.statusRead  = rdStrobe && strobes.statusSel;
    strobes.frameWrite  = wrStrobe && inWindow && (offs == OFFS_W'(FRAME_OFFS));
  end
endmodule

// File: rtl/snd_port_dpath.sv
module snd_port_dpath
  import snd_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [SLOT_N-1:0] slotHit,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [LEN_N-1:0]  lenActive,
  input  logic              smpActive,
  input  logic              smpIrq,
  input  logic              frameIrqReq,
  output logic [SLOT_N-1:0] regWr,
  output logic [DATA_W-1:0] regWrData,
  output logic [CHAN_N-1:0] chanEnable,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busLatch,
  output logic              frameIrqFlag
);
  logic              irqInhibit;
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    statusWord = {smpIrq, frameIrqFlag, 1'b0, smpActive, lenActive};
    rdData     = strobes.statusSel ? statusWord : busLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWr        <= '0;
      regWrData    <= '0;
      chanEnable   <= '0;
      busLatch     <= '0;
      irqInhibit   <= 1'b0;
      frameIrqFlag <= 1'b0;
    end else begin
      regWr <= slotHit;
      if (strobes.busWrite) begin
        regWrData <= cpuWrData;
        busLatch  <= cpuWrData;
      end else if (strobes.statusRead) begin
        busLatch <= statusWord;
      end
      if (strobes.statusWrite) chanEnable <= cpuWrData[CHAN_N-1:0];
      if (strobes.frameWrite) irqInhibit <= cpuWrData[INHIBIT_BIT];
      if (strobes.frameWrite && cpuWrData[INHIBIT_BIT]) frameIrqFlag <= 1'b0;
      else if (frameIrqReq && !irqInhibit)              frameIrqFlag <= 1'b1;
      else if (strobes.statusRead)                      frameIrqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/snd_status_port.sv
module snd_status_port
  import snd_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [3:0]        lenActive,
  input  logic              smpActive,
  input  logic              smpIrq,
  input  logic              frameIrqReq,
  output logic [23:0]       regWr,
  output logic [7:0]        regWrData,
  output logic [4:0]        chanEnable,
  output logic [7:0]        rdData
);
  portStrobes_t      strobes;
  logic [SLOT_N-1:0] slotHit;
  logic [DATA_W-1:0] busLatch;
  logic              frameIrqFlag;

  snd_port_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .cpuAddr (cpuAddr),
    .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe),
    .slotHit (slotHit),
    .strobes (strobes)
  );

  snd_port_dpath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .slotHit     (slotHit),
    .cpuWrData   (cpuWrData),
    .lenActive   (lenActive),
    .smpActive   (smpActive),
    .smpIrq      (smpIrq),
    .frameIrqReq (frameIrqReq),
    .regWr       (regWr),
    .regWrData   (regWrData),
    .chanEnable  (chanEnable),
    .rdData      (rdData),
    .busLatch    (busLatch),
    .frameIrqFlag(frameIrqFlag)
  );
endmodule

// File: rtl/snd_status_port_chk.sv
module snd_status_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [7:0]        cpuWrData,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic              frameIrqReq,
  input logic [23:0]       regWr,
  input logic [4:0]        chanEnable,
  input logic [7:0]        rdData,
  input logic [7:0]        busLatch,
  input logic              frameIrqFlag
);
  localparam logic [ADDR_W-1:0] STAT_A  = BASE_ADDR + ADDR_W'('h15);
  localparam logic [ADDR_W-1:0] FRAME_A = BASE_ADDR + ADDR_W'('h17);
  localparam logic [ADDR_W-1:0] HOLE_A  = BASE_ADDR + ADDR_W'('h09);

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWr));
  a_r3_only_after_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> regWr == '0);
  a_r4_hole_silent: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && (cpuAddr == HOLE_A || cpuAddr == STAT_A)) |=> regWr == '0);
  a_r5_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && cpuAddr == STAT_A) |=> chanEnable == $past(cpuWrData[4:0]));
  a_r6_bit5_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == STAT_A) |-> rdData[5] == 1'b0);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && cpuAddr == STAT_A && !frameIrqReq && !wrStrobe) |=> !frameIrqFlag);
  a_r8_peek_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (frameIrqFlag && !rdStrobe && !wrStrobe) |=> frameIrqFlag);
  a_r9_write_latch: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> busLatch == $past(cpuWrData));
  a_r10_inhibit_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && cpuAddr == FRAME_A && cpuWrData[6]) |=> !frameIrqFlag);
endmodule

bind snd_status_port snd_status_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
  .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .frameIrqReq(frameIrqReq),
  .regWr(regWr), .chanEnable(chanEnable), .rdData(rdData),
  .busLatch(busLatch), .frameIrqFlag(frameIrqFlag)
);

// File: tb/sim_snd_status_port.sv
module sim_snd_status_port;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] BASE = 16'h4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [3:0]  lenActive = '0;
  logic        smpActive = 1'b0, smpIrq = 1'b0, frameIrqReq = 1'b0;
  logic [23:0] regWr;
  logic [7:0]  regWrData, rdData;
  logic [4:0]  chanEnable;
  int testsRun = 0, testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_status_port u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .lenActive(lenActive),
    .smpActive(smpActive), .smpIrq(smpIrq), .frameIrqReq(frameIrqReq),
    .regWr(regWr), .regWrData(regWrData), .chanEnable(chanEnable), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpuAddr = a; cpuWrData = d; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0; #1;
  endtask

  task automatic pulseReq();
    @(negedge clk); frameIrqReq = 1'b1;
    @(negedge clk); frameIrqReq = 1'b0; #1;
  endtask

  task automatic peekAt(input logic [15:0] a);
    cpuAddr = a; #1;
  endtask

  task automatic testReset();
    check("R1 regWr", regWr, 0);
    check("R1 chanEnable", chanEnable, 0);
    peekAt(BASE); check("R1 latch", rdData, 8'h00);
    peekAt(BASE + 16'h15); check("R1 status/flag", rdData, 8'h00);
  endtask

  task automatic testDecode();
    for (int o = 0; o < 24; o++) begin
      logic mapped;
      logic [7:0] d;
      mapped = !(o == 9 || o == 13 || o == 20 || o == 21 || o == 22);
      d = 8'(o) ^ 8'h81;
      doWrite(BASE + 16'(o), d);
      if (mapped) begin
        check($sformatf("R2 strobe offs %0h", o), regWr, 24'(1) << o);
        check($sformatf("R2 data offs %0h", o), regWrData, d);
      end else begin
        check($sformatf("R4 hole offs %0h", o), regWr, 0);
      end
      @(negedge clk); #1;
      check($sformatf("R3 pulse width offs %0h", o), regWr, 0);
    end
  endtask

  task automatic testOutside();
    doWrite(16'h3FFF, 8'hA5);
    check("R4 below window", regWr, 0);
    peekAt(BASE + 16'h02); check("R9 latch after outside write", rdData, 8'hA5);
    doWrite(16'h4018, 8'h3C);
    check("R4 above window", regWr, 0);
    peekAt(BASE + 16'h16); check("R9 latch via hole read", rdData, 8'h3C);
  endtask

  task automatic testEnable();
    doWrite(BASE + 16'h15, 8'h1F); check("R5 all on", chanEnable, 5'h1F);
    doWrite(BASE + 16'h15, 8'h0A); check("R5 pattern", chanEnable, 5'h0A);
    doWrite(BASE + 16'h15, 8'hE0); check("R5 upper bits ignored", chanEnable, 5'h00);
  endtask

  task automatic testStatus();
    lenActive = 4'b1001; smpActive = 1'b0; smpIrq = 1'b1;
    peekAt(BASE + 16'h15); check("R6 pattern A", rdData, 8'h89);
    lenActive = 4'b0110; smpActive = 1'b1; smpIrq = 1'b0;
    peekAt(BASE + 16'h15); check("R6 pattern B", rdData, 8'h16);
  endtask

  task automatic testIrq();
    lenActive = 4'b0101; smpActive = 1'b1; smpIrq = 1'b0;
    pulseReq();
    peekAt(BASE + 16'h15); check("R7 flag set", rdData, 8'h55);
    @(negedge clk); #1;
    check("R8 peek keeps flag", rdData, 8'h55);
    @(negedge clk); rdStrobe = 1'b1; #1;
    check("R6 value during read", rdData, 8'h55);
    @(negedge clk); rdStrobe = 1'b0; #1;
    check("R7 read clears", rdData, 8'h15);
    peekAt(BASE + 16'h01); check("R9 latch holds status", rdData, 8'h55);
    peekAt(BASE + 16'h15);
    @(negedge clk); frameIrqReq = 1'b1; rdStrobe = 1'b1;
    @(negedge clk); frameIrqReq = 1'b0; rdStrobe = 1'b0; #1;
    check("R7 request beats read", rdData, 8'h55);
  endtask

  task automatic testInhibit();
    doWrite(BASE + 16'h17, 8'h40);
    peekAt(BASE + 16'h15); check("R10 inhibit clears flag", rdData, 8'h15);
    pulseReq();
    check("R10 request ignored", rdData, 8'h15);
    doWrite(BASE + 16'h17, 8'h00);
    pulseReq();
    peekAt(BASE + 16'h15); check("R10 released", rdData, 8'h55);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    testReset();
    testDecode();
    testOutside();
    testEnable();
    testStatus();
    testIrq();
    testInhibit();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule